// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a core's load/store front end and its first-level cache. It records every request sent toward the cache and not yet finished. Read-class requests (loads and instruction fetches) go in one small associative table, and write-class requests (stores, read-modify-write halves, load-linked, store-conditional, locked read-modify-write halves, flushes) go in another. Each entry holds the cache-line address, the request kind and the cycle it was accepted. A request offered on the request port gets an answer in the same cycle. It is accepted, refused because capacity is exhausted, or refused because a pending entry already covers the same line. Completion callbacks name a line and a table. They retire the matching entry and report its kind and total latency.

An age watchdog guards against lost completions. It is a two-state machine. In `WD_IDLE` it waits. An accepted request moves it to `WD_ARMED`, unless the `drain` input is high (the *arm* transition). In `WD_ARMED` it counts `THRESH` cycles and then expires. On expiry, any entry whose age is at least `THRESH` sets the sticky `deadlock` flag. After an expiry it stays in `WD_ARMED` with a fresh count if entries remain (the *rearm* transition). Otherwise it returns to `WD_IDLE` (the *expire-to-idle* transition). Four saturating counters record each kind of alias refusal.

Top module: `req_tracker`

## Requirements
- R1: After reset, `outstanding` is 0, `deadlock` is 0 and all four alias counters are 0.
- R2: A valid request gets status 1 (full), with nothing inserted, when `outstanding` equals `MAX_OUT` or when its own table already holds `DEPTH` entries. This check takes priority over the alias checks.
- R3: A write-class request (kind codes 2 to 9; 2 is a plain store) whose line is present in the read table gets status 2 (aliased), and `alias_st_ld` increments.
- R4: A write-class request whose line is absent from the read table but present in the write table gets status 2, and `alias_st_st` increments. The pending entry keeps its original kind and issue cycle.
- R5: A read-class request (kind 0 load, kind 1 fetch) gets status 2 when its line is present in the write table, which increments `alias_ld_st`. Otherwise, if the line is present in the read table, it gets status 2 and `alias_ld_ld` increments.
- R6: Any other valid request gets status 0 (ready). It is inserted into its table with the current cycle recorded, and `outstanding` rises by one after the clock edge.
- R7: A completion whose line matches an entry in the table chosen by `cpl_is_write` (1 = write table) asserts `cpl_hit` in the same cycle. It reports that entry's kind and, in `cpl_latency`, the number of clock edges from the acceptance edge to the completion edge. The entry is removed at that edge.
- R8: A completion that matches no entry in the chosen table asserts `cpl_err`, not `cpl_hit`, and leaves the tables and `outstanding` unchanged.
- R9: `outstanding` always equals the read-table occupancy plus the write-table occupancy and never exceeds `MAX_OUT`.
- R10: When an entry is accepted with the watchdog idle and `drain` low, `deadlock` rises exactly `THRESH` clock edges after the acceptance edge if that entry is still pending. Once set, `deadlock` stays set until reset.
- R11: An acceptance made while `drain` is high does not arm the watchdog. With no other acceptance, `deadlock` stays 0 however long that entry stays pending.
- R12: Each alias counter saturates at 2^`SAT_W` - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drain | input | 1 | Suppresses watchdog arming while high |
| req_valid | input | 1 | Request offered this cycle |
| req_kind | input | 4 | Request kind code (0 load, 1 fetch, 2..9 write-class) |
| req_line | input | ADDR_W | Cache-line address of the request |
| req_status | output | 2 | 0 ready, 1 full, 2 aliased; valid while req_valid |
| cpl_valid | input | 1 | Completion offered this cycle |
| cpl_is_write | input | 1 | Completion targets the write table when 1 |
| cpl_line | input | ADDR_W | Cache-line address being completed |
| cpl_hit | output | 1 | Completion matched an entry |
| cpl_err | output | 1 | Completion matched nothing |
| cpl_kind | output | 4 | Kind of the matched entry |
| cpl_latency | output | TS_W | Cycles the matched entry was outstanding |
| outstanding | output | OUT_W | Number of pending entries |
| deadlock | output | 1 | Sticky aged-entry flag |
| alias_st_ld | output | SAT_W | Write-class refused on a pending read |
| alias_st_st | output | SAT_W | Write-class refused on a pending write |
| alias_ld_ld | output | SAT_W | Read-class refused on a pending read |
| alias_ld_st | output | SAT_W | Read-class refused on a pending write |

## Verification
The hardest situation to reach is a full-status refusal that comes from one table being full while the total is still below `MAX_OUT`. It is also hard to make the full check win over a simultaneous alias match. Random stimulus draws lines from only six addresses and offers completions about half the time, so tables fill and alias often. A directed run fills the read table to `DEPTH` and then the total to `MAX_OUT`. The watchdog's exact firing edge and its drain suppression are reached only by directed waits with no completion.

// File: rtl/rqt_pkg.sv
`timescale 1ns/1ps
package rqt_pkg;
    typedef enum logic [3:0] {
        K_LOAD   = 4'd0,
        K_IFETCH = 4'd1,
        K_STORE  = 4'd2,
        K_RMW_RD = 4'd3,
        K_RMW_WR = 4'd4,
        K_LINK   = 4'd5,
        K_COND   = 4'd6,
        K_LRMW_RD = 4'd7,
        K_LRMW_WR = 4'd8,
        K_FLUSH  = 4'd9
    } kind_e;

    typedef enum logic [1:0] {
        S_READY = 2'd0,
        S_FULL  = 2'd1,
        S_ALIAS = 2'd2
    } status_e;

    typedef enum logic {
        WD_IDLE,
        WD_ARMED
    } wd_state_e;

    // Table index: 0 = read-class, 1 = write-class
    function automatic logic is_write_class(input logic [3:0] k);
        return k >= K_STORE;
    endfunction
endpackage

// File: rtl/rqt_cam.sv
`timescale 1ns/1ps
module rqt_cam #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int TS_W   = 16,
    parameter int THRESH = 32,
    parameter int OCC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now,
    input  logic [ADDR_W-1:0] look_line,
    input  logic              ins_en,
    input  logic [3:0]        ins_kind,
    input  logic              ret_en,
    input  logic [ADDR_W-1:0] ret_line,
    output logic              look_hit,
    output logic              full,
    output logic              ret_hit,
    output logic [3:0]        ret_kind,
    output logic [TS_W-1:0]   ret_ts,
    output logic [OCC_W-1:0]  occ,
    output logic              aged
);
    logic [DEPTH-1:0]  vld_q;
    logic [ADDR_W-1:0] line_q [DEPTH];
    logic [3:0]        kind_q [DEPTH];
    logic [TS_W-1:0]   ts_q   [DEPTH];
    logic [DEPTH-1:0]  free_sel, ret_sel;
    logic              got_free;

    always_comb begin
        look_hit = 1'b0;
        ret_hit  = 1'b0;
        ret_kind = '0;
        ret_ts   = '0;
        aged     = 1'b0;
        occ      = '0;
        free_sel = '0;
        ret_sel  = '0;
        got_free = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (vld_q[i] && line_q[i] == look_line) look_hit = 1'b1;
            if (vld_q[i] && line_q[i] == ret_line) begin
                ret_hit    = 1'b1;
                ret_sel[i] = 1'b1;
                ret_kind   = kind_q[i];
                ret_ts     = ts_q[i];
            end
            if (vld_q[i] && (now - ts_q[i]) >= TS_W'(THRESH)) aged = 1'b1;
            if (vld_q[i]) occ = occ + OCC_W'(1);
            if (!vld_q[i] && !got_free) begin
                free_sel[i] = 1'b1;
                got_free    = 1'b1;
            end
        end
        full = !got_free;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                line_q[i] <= '0;
                kind_q[i] <= '0;
                ts_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ret_en && ret_sel[i]) vld_q[i] <= 1'b0;
                if (ins_en && free_sel[i]) begin
                    vld_q[i]  <= 1'b1;
                    line_q[i] <= look_line;
                    kind_q[i] <= ins_kind;
                    ts_q[i]   <= now;
                end
            end
        end
    end
endmodule

// File: rtl/rqt_watchdog.sv
`timescale 1ns/1ps
module rqt_watchdog #(
    parameter int THRESH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic drain,
    input  logic pending_next,
    input  logic aged,
    output logic deadlock
);
    import rqt_pkg::*;
    localparam int CW = $clog2(THRESH + 1);

    wd_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           dl_q, dl_d;
    logic           expire;

    assign expire = (state_q == WD_ARMED) && (cnt_q == CW'(THRESH - 1));

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WD_IDLE: begin
                if (arm_req && !drain) begin
                    state_d = WD_ARMED;
                    cnt_d   = '0;
                end
            end
            WD_ARMED: begin
                if (expire) begin
                    state_d = pending_next ? WD_ARMED : WD_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: state_d = WD_IDLE;
        endcase
    end

    // output process
    always_comb begin
        dl_d = dl_q | (expire && aged);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
            dl_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            dl_q    <= dl_d;
        end
    end

    assign deadlock = dl_q;
endmodule

// File: rtl/req_tracker.sv
`timescale 1ns/1ps
module req_tracker #(
    parameter int ADDR_W  = 16,
    parameter int DEPTH   = 4,
    parameter int MAX_OUT = 6,
    parameter int THRESH  = 32,
    parameter int TS_W    = 16,
    parameter int SAT_W   = 3,
    parameter int OUT_W   = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drain,
    input  logic              req_valid,
    input  logic [3:0]        req_kind,
    input  logic [ADDR_W-1:0] req_line,
    output logic [1:0]        req_status,
    input  logic              cpl_valid,
    input  logic              cpl_is_write,
    input  logic [ADDR_W-1:0] cpl_line,
    output logic              cpl_hit,
    output logic              cpl_err,
    output logic [3:0]        cpl_kind,
    output logic [TS_W-1:0]   cpl_latency,
    output logic [OUT_W-1:0]  outstanding,
    output logic              deadlock,
    output logic [SAT_W-1:0]  alias_st_ld,
    output logic [SAT_W-1:0]  alias_st_st,
    output logic [SAT_W-1:0]  alias_ld_ld,
    output logic [SAT_W-1:0]  alias_ld_st
);
    import rqt_pkg::*;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [TS_W-1:0]   now_q;
    logic [OUT_W-1:0]  cnt_q, cnt_d;
    logic [1:0]        hit, tfull, rhit, ins_en, ret_en, aged;
    logic [3:0]        rkind [2];
    logic [TS_W-1:0]   rts   [2];
    logic [OCC_W-1:0]  occ   [2];
    logic              wr_req, cap_full, aliased, accept;
    logic [3:0]        alias_ev;
    logic [SAT_W-1:0]  sat_q [4];
    status_e           status;

    for (genvar t = 0; t < 2; t++) begin : g_tab
        rqt_cam #(
            .DEPTH(DEPTH), .ADDR_W(ADDR_W), .TS_W(TS_W),
            .THRESH(THRESH), .OCC_W(OCC_W)
        ) u_cam (
            .clk(clk), .rst_n(rst_n), .now(now_q),
            .look_line(req_line), .ins_en(ins_en[t]), .ins_kind(req_kind),
            .ret_en(ret_en[t]), .ret_line(cpl_line),
            .look_hit(hit[t]), .full(tfull[t]), .ret_hit(rhit[t]),
            .ret_kind(rkind[t]), .ret_ts(rts[t]), .occ(occ[t]), .aged(aged[t])
        );
    end

    // request decision
    always_comb begin
        wr_req   = is_write_class(req_kind);
        cap_full = (cnt_q >= OUT_W'(MAX_OUT)) || tfull[wr_req];
        aliased  = hit[0] || hit[1];
        if (cap_full)     status = S_FULL;
        else if (aliased) status = S_ALIAS;
        else              status = S_READY;
        accept    = req_valid && (status == S_READY);
        ins_en[0] = accept && !wr_req;
        ins_en[1] = accept && wr_req;
        alias_ev[0] = req_valid && !cap_full &&  wr_req && hit[0];
        alias_ev[1] = req_valid && !cap_full &&  wr_req && !hit[0] && hit[1];
        alias_ev[2] = req_valid && !cap_full && !wr_req && !hit[1] && hit[0];
        alias_ev[3] = req_valid && !cap_full && !wr_req && hit[1];
    end

    // completion path
    always_comb begin
        ret_en[0]   = cpl_valid && !cpl_is_write;
        ret_en[1]   = cpl_valid &&  cpl_is_write;
        cpl_hit     = cpl_valid && rhit[cpl_is_write];
        cpl_err     = cpl_valid && !rhit[cpl_is_write];
        cpl_kind    = rkind[cpl_is_write];
        cpl_latency = now_q - rts[cpl_is_write];
        cnt_d       = cnt_q + OUT_W'(accept) - OUT_W'(cpl_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_q <= '0;
            cnt_q <= '0;
        end else begin
            now_q <= now_q + TS_W'(1);
            cnt_q <= cnt_d;
        end
    end

    for (genvar a = 0; a < 4; a++) begin : g_sat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sat_q[a] <= '0;
            else if (alias_ev[a] && sat_q[a] != {SAT_W{1'b1}})
                sat_q[a] <= sat_q[a] + SAT_W'(1);
        end
    end

    rqt_watchdog #(.THRESH(THRESH)) u_wd (
        .clk(clk), .rst_n(rst_n), .arm_req(accept), .drain(drain),
        .pending_next(cnt_d != '0), .aged(aged[0] || aged[1]),
        .deadlock(deadlock)
    );

    assign req_status  = status;
    assign outstanding = cnt_q;
    assign alias_st_ld = sat_q[0];
    assign alias_st_st = sat_q[1];
    assign alias_ld_ld = sat_q[2];
    assign alias_ld_st = sat_q[3];
endmodule

// File: rtl/req_tracker_chk.sv
`timescale 1ns/1ps
module req_tracker_chk #(
    parameter int MAX_OUT = 6,
    parameter int OUT_W   = 3,
    parameter int OCC_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_status,
    input logic             cpl_valid,
    input logic             cpl_err,
    input logic [OUT_W-1:0] outstanding,
    input logic [OCC_W-1:0] rd_occ,
    input logic [OCC_W-1:0] wr_occ,
    input logic             deadlock
);
    AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) == int'(rd_occ) + int'(wr_occ)); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) <= MAX_OUT); // R9

    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_status == 2'd1 |=> outstanding <= $past(outstanding)); // R2

    AST_ALIAS_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_status == 2'd2 |=> outstanding <= $past(outstanding)); // R3

    AST_READY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_status == 2'd0 && !cpl_valid
        |=> outstanding == $past(outstanding) + OUT_W'(1)); // R6

    AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_err && !req_valid |=> outstanding == $past(outstanding)); // R8

    AST_DEADLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |=> deadlock); // R10
endmodule

bind req_tracker req_tracker_chk #(
    .MAX_OUT(MAX_OUT), .OUT_W(OUT_W), .OCC_W(OCC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_status(req_status),
    .cpl_valid(cpl_valid), .cpl_err(cpl_err), .outstanding(outstanding),
    .rd_occ(occ[0]), .wr_occ(occ[1]), .deadlock(deadlock)
);

// File: tb/req_tracker_tb.sv
`timescale 1ns/1ps
module req_tracker_tb;
    localparam int DEPTH = 4, MAX_OUT = 6, THRESH = 20, SATMAX = 7;

    logic clk = 1'b0, rst_n = 1'b0, drain = 1'b0;
    logic req_valid = 1'b0, cpl_valid = 1'b0, cpl_is_write = 1'b0;
    logic [3:0] req_kind = '0;
    logic [15:0] req_line = '0, cpl_line = '0;
    logic [1:0] req_status;
    logic cpl_hit, cpl_err, deadlock;
    logic [3:0] cpl_kind;
    logic [15:0] cpl_latency;
    logic [2:0] outstanding;
    logic [2:0] alias_st_ld, alias_st_st, alias_ld_ld, alias_ld_st;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    bit          mv  [2][DEPTH];
    logic [15:0] ml  [2][DEPTH];
    logic [3:0]  mk  [2][DEPTH];
    int          mts [2][DEPTH];
    int          mcnt;
    int          mal [4];

    req_tracker #(.THRESH(THRESH)) u_dut (
        .clk(clk), .rst_n(rst_n), .drain(drain),
        .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line),
        .req_status(req_status), .cpl_valid(cpl_valid), .cpl_is_write(cpl_is_write),
        .cpl_line(cpl_line), .cpl_hit(cpl_hit), .cpl_err(cpl_err),
        .cpl_kind(cpl_kind), .cpl_latency(cpl_latency), .outstanding(outstanding),
        .deadlock(deadlock), .alias_st_ld(alias_st_ld), .alias_st_st(alias_st_st),
        .alias_ld_ld(alias_ld_ld), .alias_ld_st(alias_ld_st)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic bit mhit(input int t, input logic [15:0] l);
        for (int i = 0; i < DEPTH; i++) if (mv[t][i] && ml[t][i] == l) return 1;
        return 0;
    endfunction

    function automatic int mocc(input int t);
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (mv[t][i]) n++;
        return n;
    endfunction

    function automatic int sat_inc(input int v);
        return (v >= SATMAX) ? SATMAX : v + 1;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 0; cpl_valid = 0; drain = 0;
        for (int t = 0; t < 2; t++) for (int i = 0; i < DEPTH; i++) mv[t][i] = 0;
        mcnt = 0;
        for (int a = 0; a < 4; a++) mal[a] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input bit rv, input logic [3:0] rk, input logic [15:0] rl,
                        input bit cv, input bit cw, input logic [15:0] cl, input bit drn);
        int es, ci, wt;
        bit h0, h1;
        string tag;
        @(negedge clk);
        chk(outstanding == 3'(mcnt), "R9", outstanding, mcnt);
        chk(alias_st_ld == 3'(mal[0]), "R12", alias_st_ld, mal[0]);
        chk(alias_st_st == 3'(mal[1]), "R12", alias_st_st, mal[1]);
        chk(alias_ld_ld == 3'(mal[2]), "R12", alias_ld_ld, mal[2]);
        chk(alias_ld_st == 3'(mal[3]), "R12", alias_ld_st, mal[3]);
        req_valid = rv; req_kind = rk; req_line = rl;
        cpl_valid = cv; cpl_is_write = cw; cpl_line = cl; drain = drn;
        #1;
        es = -1;
        wt = (rk >= 4'd2) ? 1 : 0;
        if (rv) begin
            h0 = mhit(0, rl); h1 = mhit(1, rl);
            if (mcnt >= MAX_OUT || mocc(wt) >= DEPTH) begin es = 1; tag = "R2"; end
            else if (wt == 1 && h0) begin es = 2; tag = "R3"; mal[0] = sat_inc(mal[0]); end
            else if (wt == 1 && h1) begin es = 2; tag = "R4"; mal[1] = sat_inc(mal[1]); end
            else if (wt == 0 && h1) begin es = 2; tag = "R5"; mal[3] = sat_inc(mal[3]); end
            else if (wt == 0 && h0) begin es = 2; tag = "R5"; mal[2] = sat_inc(mal[2]); end
            else begin es = 0; tag = "R6"; end
            chk(req_status == 2'(es), tag, req_status, es);
        end
        ci = -1;
        if (cv) begin
            for (int i = 0; i < DEPTH; i++) if (mv[cw][i] && ml[cw][i] == cl) ci = i;
            if (ci >= 0) begin
                chk(cpl_hit == 1'b1, "R7", cpl_hit, 1);
                chk(cpl_kind == mk[cw][ci], "R7", cpl_kind, mk[cw][ci]);
                chk(cpl_latency == 16'(cyc - mts[cw][ci]), "R7", cpl_latency, 16'(cyc - mts[cw][ci]));
                mv[cw][ci] = 0; mcnt--;
            end else begin
                chk(cpl_err == 1'b1 && cpl_hit == 1'b0, "R8", {cpl_err, cpl_hit}, 2);
            end
        end
        if (es == 0) begin
            for (int i = 0; i < DEPTH; i++) if (!mv[wt][i] && !(cv && cw == wt[0] && i == ci)) begin
                mv[wt][i] = 1; ml[wt][i] = rl; mk[wt][i] = rk; mts[wt][i] = cyc;
                mcnt++;
                break;
            end
        end
        @(posedge clk); #1;
        req_valid = 0; cpl_valid = 0; drain = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset();
        @(negedge clk);
        chk(outstanding == 0 && deadlock == 0, "R1", {outstanding, deadlock}, 0);
        chk((alias_st_ld | alias_st_st | alias_ld_ld | alias_ld_st) == 0, "R1", alias_st_ld, 0);

        // directed: accept, complete, alias cases, miss
        step(1, 4'd0, 16'd1, 0, 0, 0, 0);   // R6 load accepted
        idle(3);
        step(0, 0, 0, 1, 0, 16'd1, 0);      // R7 latency 4
        step(1, 4'd0, 16'd2, 0, 0, 0, 0);   // load line 2
        step(1, 4'd2, 16'd2, 0, 0, 0, 0);   // R3 store on pending load
        step(1, 4'd2, 16'd3, 0, 0, 0, 0);   // store line 3
        step(1, 4'd4, 16'd3, 0, 0, 0, 0);   // R4 rmw-write on pending store
        step(0, 0, 0, 1, 1, 16'd3, 0);      // R4 original kind kept
        step(1, 4'd6, 16'd4, 0, 0, 0, 0);   // write line 4
        step(1, 4'd0, 16'd4, 0, 0, 0, 0);   // R5 load on pending write
        step(1, 4'd1, 16'd2, 0, 0, 0, 0);   // R5 fetch on pending load
        step(0, 0, 0, 1, 0, 16'd9, 0);      // R8 miss
        step(0, 0, 0, 1, 1, 16'd2, 0);      // R8 wrong table
        // R2: fill read table, then total
        step(1, 4'd0, 16'd10, 0, 0, 0, 0);
        step(1, 4'd0, 16'd11, 0, 0, 0, 0);
        step(1, 4'd1, 16'd12, 0, 0, 0, 0);
        step(1, 4'd0, 16'd13, 0, 0, 0, 0);  // R2 read table full
        step(1, 4'd0, 16'd2, 0, 0, 0, 0);   // R2 full wins over alias
        step(1, 4'd9, 16'd20, 0, 0, 0, 0);  // total reaches MAX_OUT
        step(1, 4'd2, 16'd21, 0, 0, 0, 0);  // R2 total full
        step(1, 4'd2, 16'd22, 1, 0, 16'd10, 0); // R2 full with same-cycle retire
        idle(1);

        // random phase
        do_reset();
        for (int n = 0; n < 800; n++) begin
            bit rv, cv, cw;
            logic [3:0] rk;
            logic [15:0] rl, cl;
            int pick;
            rv = ($urandom % 10) < 7;
            rk = 4'($urandom % 10);
            rl = 16'($urandom % 6);
            cv = ($urandom % 2) == 1;
            cw = ($urandom % 2) == 1;
            cl = 16'($urandom % 6);
            pick = $urandom % DEPTH;
            if (mv[cw][pick]) cl = ml[cw][pick];
            step(rv, rk, rl, cv, cw, cl, 0);
        end
        idle(1);

        // R12 saturation
        do_reset();
        step(1, 4'd0, 16'd7, 0, 0, 0, 0);
        for (int k = 0; k < 9; k++) step(1, 4'd0, 16'd7, 0, 0, 0, 0);
        idle(1);
        chk(alias_ld_ld == 3'(SATMAX), "R12", alias_ld_ld, SATMAX);

        // R10 exact firing edge
        do_reset();
        step(1, 4'd2, 16'd5, 0, 0, 0, 0);
        for (int j = 1; j <= THRESH; j++) begin
            @(posedge clk); #1;
            if (j == THRESH - 1) chk(deadlock == 1'b0, "R10", deadlock, 0);
            if (j == THRESH)     chk(deadlock == 1'b1, "R10", deadlock, 1);
        end
        repeat (5) @(posedge clk);
        #1 chk(deadlock == 1'b1, "R10", deadlock, 1);

        // R11 drain suppresses arming
        do_reset();
        step(1, 4'd0, 16'd6, 0, 0, 0, 1);
        repeat (3 * THRESH) @(posedge clk);
        #1 chk(deadlock == 1'b0, "R11", deadlock, 0);
        step(1, 4'd0, 16'd8, 0, 0, 0, 0);
        repeat (THRESH) @(posedge clk);
        #1 chk(deadlock == 1'b1, "R10", deadlock, 1);

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule